// File: doc/BRIEF.md
# Selectable-Source Timebase Counter

This block keeps a 24-bit timebase that runs freely and wraps around. Each cycle the counter either advances by one or holds. The choice depends on a tick taken from one of several sources, which then passes through a programmable prescaler. The sources are:

- a divide-by-eight of the system clock;
- that same divided clock gated by an external pin, which makes the counter a pulse accumulator;
- rising, falling or both edges of the external pin;
- the rising edge of a peripheral timebase strobe;
- no source at all, which freezes the count.

The external pin is first synchronized with two flops. It then passes through a digital noise filter, which has two modes. In two-sample mode the output follows the input once two successive samples agree. In integrating mode a small up/down counter must saturate before the output changes. The filter sample strobe is either every second system clock or the system clock divided by the prescale factor. The filtered pin is also brought out as an output.

The block runs on a single clock. The strobe input is assumed synchronous and no faster than half the system clock.

Top module: `tbase_clkctl`

## Requirements
- R1: During and after reset, `count` is zero and `pin_filt` is low.
- R2: With `src_sel` = 100 the source ticks once every 8 system clocks whatever the pin does.
- R3: The prescaler passes one of every `presc`+1 source ticks (divide by 1 to 64 for `presc` 0 to 63), and each passed tick advances `count` on the following clock.
- R4: With `src_sel` = 000 the divide-by-eight tick counts only while `pin_filt` is high, so a held-low pin stops the count.
- R5: `src_sel` 001, 010 and 011 tick once per rising, falling, or either edge of `pin_filt`, respectively.
- R6: With `src_sel` = 101 each rising edge of `pstrobe` is one source tick.
- R7: With `src_sel` = 111 or 110 nothing ticks and `count` holds its value.
- R8: With `filt_integ` = 0 the filter output takes the synchronized pin value only when two consecutive samples agree; a pin pulse spanning one sample is rejected, one spanning two consecutive samples is passed.
- R9: With `filt_integ` = 1 a 2-bit saturating counter steps up on a high sample and down on a low one; the output goes high only at 3 and low only at 0.
- R10: With `filt_clk_sel` = 0 the filter samples every second clock; with `filt_clk_sel` = 1 it samples once every `presc`+1 clocks.
- R11: Any change of `presc` clears the prescaler's internal divider, so the first divided tick under a new value arrives without waiting out the old one.
- R12: `count` only ever holds or steps by exactly one, modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 1 | External clock/gate pin, asynchronous |
| pstrobe | input | 1 | Peripheral timebase strobe, synchronous |
| src_sel | input | 3 | Tick source select |
| presc | input | 6 | Prescale value, divide by presc+1 |
| filt_integ | input | 1 | 0: two-sample filter, 1: integrating filter |
| filt_clk_sel | input | 1 | 0: sample every 2nd clock, 1: sample at clock/(presc+1) |
| count | output | 24 | Timebase value |
| pin_filt | output | 1 | Filtered external pin |

## Verification
The bench measures count advance over windows that are whole multiples of each source period. A wrong divisor, a swapped edge polarity or an ungated accumulator therefore shows up as an exact count mismatch. The filter tests use pulses sized to land on one sample or on two. A filter that follows single samples would let the short glitch through. An integrator without hysteresis would drop the output on a brief dip. A filter clocked from the wrong strobe would pass or reject the wrong pulse. The prescale-change test shrinks the divisor mid-count: a divider that is not cleared would run past the new limit and stall the count for hundreds of clocks.

// File: rtl/tbase_clkctl.sv
module tbase_clkctl #(
  parameter int CW = 24,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_pin,
  input  logic          pstrobe,
  input  logic [2:0]    src_sel,
  input  logic [PW-1:0] presc,
  input  logic          filt_integ,
  input  logic          filt_clk_sel,
  output logic [CW-1:0] count,
  output logic          pin_filt
);

  logic          sync0, sync1, smp, pf_q, ps_q;
  logic [2:0]    div8;
  logic [1:0]    icnt, inext;
  logic [PW-1:0] pcnt, fdiv, presc_q;
  logic          presc_chg, fdiv_hit, fclk_en, src_tick, presc_tick, rise, fall;

  assign presc_chg  = presc != presc_q;
  assign fdiv_hit   = fdiv == presc;
  assign fclk_en    = filt_clk_sel ? fdiv_hit : div8[0];
  assign rise       = pin_filt & ~pf_q;
  assign fall       = ~pin_filt & pf_q;
  assign presc_tick = src_tick && (pcnt == presc);

  always_comb begin
    case (src_sel)
      3'b000:  src_tick = (div8 == 3'd7) && pin_filt;
      3'b001:  src_tick = rise;
      3'b010:  src_tick = fall;
      3'b011:  src_tick = rise | fall;
      3'b100:  src_tick = div8 == 3'd7;
      3'b101:  src_tick = pstrobe & ~ps_q;
      default: src_tick = 1'b0;
    endcase
  end

  always_comb begin
    if (sync1) inext = (icnt == 2'd3) ? icnt : icnt + 2'd1;
    else       inext = (icnt == 2'd0) ? icnt : icnt - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0    <= 1'b0;
      sync1    <= 1'b0;
      smp      <= 1'b0;
      pf_q     <= 1'b0;
      ps_q     <= 1'b0;
      div8     <= '0;
      icnt     <= '0;
      pcnt     <= '0;
      fdiv     <= '0;
      presc_q  <= '0;
      pin_filt <= 1'b0;
      count    <= '0;
    end else begin
      sync0   <= ext_pin;
      sync1   <= sync0;
      pf_q    <= pin_filt;
      ps_q    <= pstrobe;
      div8    <= div8 + 3'd1;
      presc_q <= presc;

      if (presc_chg || fdiv_hit) fdiv <= '0;
      else                       fdiv <= fdiv + 1'b1;

      if (fclk_en) begin
        smp  <= sync1;
        icnt <= inext;
        if (filt_integ) begin
          if (inext == 2'd3)      pin_filt <= 1'b1;
          else if (inext == 2'd0) pin_filt <= 1'b0;
        end else if (sync1 == smp) begin
          pin_filt <= sync1;
        end
      end

      if (presc_chg)     pcnt <= '0;
      else if (src_tick) pcnt <= (pcnt == presc) ? '0 : pcnt + 1'b1;

      if (presc_tick) count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/tbase_clkctl_chk.sv
module tbase_clkctl_chk #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    src_sel,
  input logic [CW-1:0] count,
  input logic          pin_filt,
  input logic          sync1
);

  // R12
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> count == $past(count) + 1'b1);

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel[2:1] == 2'b11) |=> $stable(count));

  // R4
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b000 && !pin_filt) |=> $stable(count));

  // R8
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_filt) |-> pin_filt == $past(sync1));

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (count == '0 && pin_filt == 1'b0);
    end
  end

endmodule

bind tbase_clkctl tbase_clkctl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .count(count),
  .pin_filt(pin_filt), .sync1(sync1)
);

// File: tb/tbase_clkctl_bench.sv
`timescale 1ns/1ps
module tbase_clkctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_pin = 1'b0;
  logic        pstrobe = 1'b0;
  logic [2:0]  src_sel = 3'b111;
  logic [5:0]  presc = '0;
  logic        filt_integ = 1'b0;
  logic        filt_clk_sel = 1'b0;
  logic [23:0] count;
  logic        pin_filt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [1:0] pin_mode = 2'd0;
  logic seen_hi, seen_lo;
  logic [23:0] c0;

  always #10 clk = ~clk;

  tbase_clkctl u_tbase_clkctl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pstrobe(pstrobe),
    .src_sel(src_sel), .presc(presc), .filt_integ(filt_integ),
    .filt_clk_sel(filt_clk_sel), .count(count), .pin_filt(pin_filt)
  );

  // fields: src[35:33] presc[32:27] pinmode[26:25] integ[24] win[23:12] exp[11:4] req[3:0]
  // pinmode 0 low, 1 high, 2 square wave of 16 clocks
  localparam logic [35:0] VEC [12] = '{
    {3'd4, 6'd0,  2'd0, 1'b0, 12'd64,   8'd8,  4'd2},
    {3'd4, 6'd3,  2'd0, 1'b0, 12'd320,  8'd10, 4'd3},
    {3'd0, 6'd0,  2'd1, 1'b0, 12'd64,   8'd8,  4'd4},
    {3'd0, 6'd0,  2'd0, 1'b0, 12'd64,   8'd0,  4'd4},
    {3'd0, 6'd0,  2'd2, 1'b0, 12'd160,  8'd10, 4'd4},
    {3'd1, 6'd0,  2'd2, 1'b0, 12'd160,  8'd10, 4'd5},
    {3'd2, 6'd1,  2'd2, 1'b0, 12'd320,  8'd10, 4'd5},
    {3'd3, 6'd0,  2'd2, 1'b1, 12'd160,  8'd20, 4'd5},
    {3'd5, 6'd0,  2'd0, 1'b0, 12'd40,   8'd10, 4'd6},
    {3'd5, 6'd4,  2'd2, 1'b0, 12'd200,  8'd10, 4'd3},
    {3'd7, 6'd0,  2'd2, 1'b0, 12'd200,  8'd0,  4'd7},
    {3'd4, 6'd63, 2'd0, 1'b0, 12'd1024, 8'd2,  4'd3}
  };

  function automatic string rq(input logic [3:0] id);
    case (id)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      if (pin_mode == 2'd2) ext_pin = cyc[3];
      else if (pin_mode != 2'd3) ext_pin = pin_mode[0];
      pstrobe = (cyc[1:0] == 2'd0);
      if (pin_filt) seen_hi = 1'b1; else seen_lo = 1'b1;
    end
  endtask

  task automatic pulse(input logic lvl, input int n);
    pin_mode = 2'd3;
    ext_pin = ~lvl;
    tick(40);
    seen_hi = 1'b0; seen_lo = 1'b0;
    ext_pin = lvl;
    tick(n);
    ext_pin = ~lvl;
    tick(20);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    check(count == 24'd0 && pin_filt == 1'b0, "R1", int'(count), 0);
    rst_n = 1'b1;
    tick(2);
    check(count == 24'd0 && pin_filt == 1'b0, "R1", int'(count), 0);

    foreach (VEC[i]) begin
      src_sel    = VEC[i][35:33];
      presc      = VEC[i][32:27];
      pin_mode   = VEC[i][26:25];
      filt_integ = VEC[i][24];
      tick(64);
      c0 = count;
      tick(int'(VEC[i][23:12]));
      check(count - c0 == 24'(VEC[i][11:4]), rq(VEC[i][3:0]),
            int'(count - c0), int'(VEC[i][11:4]));
    end

    // R11: shrink the divisor mid-count; the next divided tick comes at once
    src_sel = 3'd4; presc = 6'd63; pin_mode = 2'd0;
    tick(300);
    c0 = count;
    presc = 6'd0;
    tick(12);
    check((count - c0 == 24'd1) || (count - c0 == 24'd2), "R11", int'(count - c0), 1);

    // R8: two-sample filter, every-other-clock sampling
    src_sel = 3'd7; presc = 6'd7; filt_integ = 1'b0; filt_clk_sel = 1'b0;
    pulse(1'b1, 1);
    check(!seen_hi, "R8", int'(seen_hi), 0);
    pulse(1'b1, 4);
    check(seen_hi, "R8", int'(seen_hi), 1);

    // R9: integrating filter rejects a short pulse and a short dip
    filt_integ = 1'b1;
    pulse(1'b1, 3);
    check(!seen_hi, "R9", int'(seen_hi), 0);
    pulse(1'b0, 3);
    check(!seen_lo, "R9", int'(seen_lo), 0);
    check(pin_filt, "R9", int'(pin_filt), 1);

    // R10: sampling at clock/(presc+1) rejects a pulse shorter than one period
    filt_integ = 1'b0; filt_clk_sel = 1'b1;
    pulse(1'b1, 6);
    check(!seen_hi, "R10", int'(seen_hi), 0);
    pulse(1'b1, 40);
    check(seen_hi, "R10", int'(seen_hi), 1);
    filt_clk_sel = 1'b0;
    pulse(1'b1, 6);
    check(seen_hi, "R10", int'(seen_hi), 1);

    // R7: reserved encoding also freezes; R12 hold then resume by one per tick
    src_sel = 3'd6; pin_mode = 2'd2;
    c0 = count;
    tick(100);
    check(count == c0, "R7", int'(count - c0), 0);
    src_sel = 3'd4; presc = 6'd0;
    tick(64);
    c0 = count;
    tick(8);
    check(count - c0 == 24'd1, "R12", int'(count - c0), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule